// File: doc/BRIEF.md
# Flash Read Data Selector

This block forms the read data of a parallel NOR flash model. A separate command sequencer owns the device's command state and presents it as an 8-bit code. The selector uses that code to decide what a bus read returns. In plain read mode, in erase setup and in any state it does not recognise, it returns the word the array supplies. In autoselect mode it returns identification words. While a program or an erase is pending it returns a status byte. In query mode it returns bytes from a device description table, which is computed from the geometry parameters.

The status byte is held here. The sequencer loads it when a program or erase starts. Every status read inverts bit 6, so polling software sees that bit toggle until the operation ends. The read offset is the low address byte scaled down by the device width, so each table entry sits at one word position. Read data is registered and appears one clock after the read strobe.

Top module: `flash_read_mux`

## Requirements
- R1: After synchronous reset, `rd_data` is 0 and the held status byte is 0.
- R2: `rd_data` is updated on the clock edge at which `rd_en` is high and is visible from that edge on. Without `rd_en` it holds its value.
- R3: The table offset is `rd_addr` shifted right by log2(DEV_BYTES). With DEV_BYTES=2, address bit 0 is ignored, so addresses 0x20 and 0x21 both select offset 0x10.
- R4: When `cmd_state` is 0x00 (read), 0x80 (erase setup) or any code not listed in R5, R7 or R9, a read returns `arr_rdata`.
- R5: When `cmd_state` is 0x90 (autoselect), offset 0 returns ID word 0 and offset 1 returns ID word 1, each zero-extended or truncated to DATA_W. Offset 2 returns 0, which reports all sectors as unprotected.
- R6: In autoselect, offset 0x0E returns ID word 2 and offset 0x0F returns ID word 3, unless that word is 16'hFFFF, in which case `arr_rdata` is returned. Every other autoselect offset returns `arr_rdata`.
- R7: When `cmd_state` is 0xA0, 0x10 or 0x30, a read returns the status byte as it was before the edge, zero-extended, and the same edge inverts status bit 6.
- R8: `stat_ld` writes `stat_val` into the status byte. A load wins over a toggle in the same cycle. In all other cases the status byte holds its value.
- R9: When `cmd_state` is 0x98 (query), offsets 0x10..0x13 return 0x51, 0x52, 0x59 and 0x02. Offsets 0x52 and above return 0.
- R10: In query mode, offset 0x27 returns log2 of the total byte size, offsets 0x2D/0x2E return the low and high bytes of NUM_SECTORS-1, and offsets 0x2F/0x30 return the low and high bytes of SECTOR_BYTES/256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Low byte of the read address |
| cmd_state | input | 8 | Command state code from the sequencer |
| arr_rdata | input | DATA_W | Array word at the read address |
| stat_ld | input | 1 | Load the status byte |
| stat_val | input | 8 | Value to load into the status byte |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block 16 bits wide, with 128 sectors of 64 KiB, an 8 MiB device. With this width, address bit 0 is dropped and the offset range goes past the end of the query table, so both the scaling rule and the zero return beyond the table are reached. The geometry gives a device-size entry of 23, a block-count field of 0x7F/0x00 and a sector-size field whose high byte carries the value (0x00/0x01). The fourth ID word is set to all ones, which reaches the array fallback at offset 0x0F, while the third ID word is returned normally.

// File: rtl/flash_read_pkg.sv
package flash_read_pkg;

    localparam logic [7:0] CMD_READ       = 8'h00;
    localparam logic [7:0] CMD_ERASE_SET  = 8'h80;
    localparam logic [7:0] CMD_AUTOSEL    = 8'h90;
    localparam logic [7:0] CMD_PROGRAM    = 8'hA0;
    localparam logic [7:0] CMD_CHIP_ERASE = 8'h10;
    localparam logic [7:0] CMD_SECT_ERASE = 8'h30;
    localparam logic [7:0] CMD_QUERY      = 8'h98;

    localparam int unsigned QUERY_LEN = 8'h52;
    localparam logic [15:0] ID_ABSENT = 16'hFFFF;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_IDENT,
        SRC_STATUS,
        SRC_QUERY
    } rd_src_e;

    typedef struct packed {
        rd_src_e    src;
        logic [7:0] off;
    } rd_sel_t;

    function automatic rd_src_e classify(input logic [7:0] code);
        case (code)
            CMD_AUTOSEL:                               return SRC_IDENT;
            CMD_PROGRAM, CMD_CHIP_ERASE, CMD_SECT_ERASE: return SRC_STATUS;
            CMD_QUERY:                                 return SRC_QUERY;
            default:                                   return SRC_ARRAY;
        endcase
    endfunction

    // Query table: fixed fields plus geometry-derived ones
    function automatic logic [7:0] query_entry(
        input logic [7:0]  idx,
        input logic [7:0]  size_log2,
        input logic [15:0] blocks_m1,
        input logic [15:0] sect_div
    );
        case (idx)
            8'h10: return 8'h51;
            8'h11: return 8'h52;
            8'h12: return 8'h59;
            8'h13: return 8'h02;
            8'h1B: return 8'h27;
            8'h1C: return 8'h36;
            8'h1F: return 8'h07;
            8'h20: return 8'h04;
            8'h21: return 8'h09;
            8'h22: return 8'h0C;
            8'h23: return 8'h01;
            8'h24: return 8'h04;
            8'h25: return 8'h0A;
            8'h26: return 8'h0D;
            8'h27: return size_log2;
            8'h28: return 8'h02;
            8'h2A: return 8'h05;
            8'h2C: return 8'h01;
            8'h2D: return blocks_m1[7:0];
            8'h2E: return blocks_m1[15:8];
            8'h2F: return sect_div[7:0];
            8'h30: return sect_div[15:8];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/fr_offset.sv
module fr_offset #(
    parameter int DEV_BYTES = 2
) (
    input  logic [7:0] addr_lo,
    output logic [7:0] off
);
    localparam int SHIFT = (DEV_BYTES > 1) ? $clog2(DEV_BYTES) : 0;

    generate
        if (SHIFT == 0) begin : g_byte
            assign off = addr_lo;
        end else begin : g_wide
            assign off = {{SHIFT{1'b0}}, addr_lo[7:SHIFT]};
        end
    endgenerate
endmodule

// File: rtl/fr_status.sv
module fr_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       toggle,
    output logic [7:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 8'h00;
        end else if (ld) begin
            q <= ld_val;
        end else if (toggle) begin
            q <= q ^ 8'h40;
        end
    end
endmodule

// File: rtl/fr_query_rom.sv
module fr_query_rom
    import flash_read_pkg::*;
#(
    parameter int SECTOR_BYTES = 65536,
    parameter int NUM_SECTORS  = 128
) (
    input  logic [7:0] off,
    output logic [7:0] q
);
    localparam int          TOTAL_LOG2 = $clog2(SECTOR_BYTES) + $clog2(NUM_SECTORS);
    localparam logic [7:0]  SIZE_L2    = 8'(TOTAL_LOG2);
    localparam logic [15:0] BLK_M1     = 16'(NUM_SECTORS - 1);
    localparam logic [15:0] SECT_DIV   = 16'(SECTOR_BYTES / 256);

    always_comb begin
        if (32'(off) >= QUERY_LEN) begin
            q = 8'h00;
        end else begin
            q = query_entry(off, SIZE_L2, BLK_M1, SECT_DIV);
        end
    end
endmodule

// File: rtl/fr_ident.sv
module fr_ident
    import flash_read_pkg::*;
#(
    parameter logic [15:0] ID0 = 16'h0001,
    parameter logic [15:0] ID1 = 16'h227E,
    parameter logic [15:0] ID2 = 16'h2213,
    parameter logic [15:0] ID3 = 16'hFFFF
) (
    input  logic [7:0]  off,
    output logic        hit,
    output logic [15:0] word
);
    always_comb begin
        hit  = 1'b0;
        word = 16'h0000;
        case (off)
            8'h00: begin hit = 1'b1; word = ID0; end
            8'h01: begin hit = 1'b1; word = ID1; end
            8'h02: begin hit = 1'b1; word = 16'h0000; end
            8'h0E: begin hit = (ID2 != ID_ABSENT); word = ID2; end
            8'h0F: begin hit = (ID3 != ID_ABSENT); word = ID3; end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_read_pkg::*;
#(
    parameter int          DEV_BYTES    = 2,
    parameter int          SECTOR_BYTES = 65536,
    parameter int          NUM_SECTORS  = 128,
    parameter logic [15:0] ID0          = 16'h0001,
    parameter logic [15:0] ID1          = 16'h227E,
    parameter logic [15:0] ID2          = 16'h2213,
    parameter logic [15:0] ID3          = 16'hFFFF,
    localparam int         DATA_W       = 8 * DEV_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [7:0]        rd_addr,
    input  logic [7:0]        cmd_state,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              stat_ld,
    input  logic [7:0]        stat_val,
    output logic [DATA_W-1:0] rd_data
);
    rd_sel_t           sel;
    logic [7:0]        off;
    logic [7:0]        stat_q;
    logic [7:0]        qry_byte;
    logic              id_hit;
    logic [15:0]       id_word;
    logic [DATA_W-1:0] nxt_data;

    fr_offset #(.DEV_BYTES(DEV_BYTES)) u_off (
        .addr_lo (rd_addr),
        .off     (off)
    );

    assign sel.src = classify(cmd_state);
    assign sel.off = off;

    fr_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .ld     (stat_ld),
        .ld_val (stat_val),
        .toggle (rd_en && (sel.src == SRC_STATUS)),
        .q      (stat_q)
    );

    fr_query_rom #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .NUM_SECTORS  (NUM_SECTORS)
    ) u_qry (
        .off (sel.off),
        .q   (qry_byte)
    );

    fr_ident #(.ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_id (
        .off  (sel.off),
        .hit  (id_hit),
        .word (id_word)
    );

    always_comb begin
        case (sel.src)
            SRC_IDENT:  nxt_data = id_hit ? DATA_W'(id_word) : arr_rdata;
            SRC_STATUS: nxt_data = DATA_W'(stat_q);
            SRC_QUERY:  nxt_data = DATA_W'(qry_byte);
            default:    nxt_data = arr_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= nxt_data;
        end
    end
endmodule

// File: rtl/flash_read_mux_chk.sv
module flash_read_mux_chk #(
    parameter int DEV_BYTES = 2,
    localparam int DATA_W   = 8 * DEV_BYTES
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [7:0]        rd_addr,
    input logic [7:0]        cmd_state,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              stat_ld,
    input logic [7:0]        stat_val,
    input logic [DATA_W-1:0] rd_data,
    input logic [7:0]        stat_q
);
    localparam int SH = (DEV_BYTES > 1) ? $clog2(DEV_BYTES) : 0;

    logic [7:0] c_off;
    logic       c_stat;
    assign c_off  = rd_addr >> SH;
    assign c_stat = (cmd_state == 8'hA0) || (cmd_state == 8'h10) || (cmd_state == 8'h30);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R4
    array_pass_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && (cmd_state == 8'h00 || cmd_state == 8'h80) |=> rd_data == $past(arr_rdata));

    // R5
    unprotected_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && cmd_state == 8'h90 && c_off == 8'h02 |=> rd_data == '0);

    // R7
    status_value_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && c_stat |=> rd_data == DATA_W'($past(stat_q)));

    // R7
    status_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && c_stat && !stat_ld |=> stat_q == ($past(stat_q) ^ 8'h40));

    // R8
    status_load_chk: assert property (@(posedge clk) disable iff (rst)
        stat_ld |=> stat_q == $past(stat_val));

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_ld && !(rd_en && c_stat) |=> $stable(stat_q));

    // R9
    query_beyond_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && cmd_state == 8'h98 && c_off >= 8'h52 |=> rd_data == '0);
endmodule

bind flash_read_mux flash_read_mux_chk #(.DEV_BYTES(DEV_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .cmd_state (cmd_state),
    .arr_rdata (arr_rdata),
    .stat_ld   (stat_ld),
    .stat_val  (stat_val),
    .rd_data   (rd_data),
    .stat_q    (stat_q)
);

// File: tb/tb_flash_read_mux.sv
module tb_flash_read_mux;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_addr = 8'h00;
    logic [7:0]    cmd_state = 8'h00;
    logic [DW-1:0] arr_rdata = '0;
    logic          stat_ld = 1'b0;
    logic [7:0]    stat_val = 8'h00;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_read_mux #(
        .DEV_BYTES    (2),
        .SECTOR_BYTES (65536),
        .NUM_SECTORS  (128),
        .ID0          (16'h0001),
        .ID1          (16'h227E),
        .ID2          (16'h2213),
        .ID3          (16'hFFFF)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .cmd_state (cmd_state),
        .arr_rdata (arr_rdata),
        .stat_ld   (stat_ld),
        .stat_val  (stat_val),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one read: drive at a falling edge, sample at the next falling edge
    task automatic rd(input logic [7:0] cmd, input logic [7:0] a,
                      input logic [DW-1:0] arr, output logic [DW-1:0] q);
        @(negedge clk);
        cmd_state = cmd; rd_addr = a; arr_rdata = arr; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] cmd, input logic [7:0] a,
                          input logic [DW-1:0] arr, input logic [DW-1:0] exp);
        logic [DW-1:0] q;
        rd(cmd, a, arr, q);
        check(req, q, exp);
    endtask

    task automatic load_status(input logic [7:0] v);
        @(negedge clk);
        stat_ld = 1'b1; stat_val = v;
        @(negedge clk);
        stat_ld = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] q;
        check("R1 reset data", rd_data, '0);
        rd(8'hA0, 8'h00, 16'h1234, q);
        check("R1 reset status", q, 16'h0000);
    endtask

    task automatic t_array;
        rd_chk("R4 read mode", 8'h00, 8'h40, 16'hBEEF, 16'hBEEF);
        rd_chk("R4 erase setup", 8'h80, 8'h06, 16'h5A5A, 16'h5A5A);
        rd_chk("R4 unknown code", 8'h77, 8'h00, 16'hC3C3, 16'hC3C3);
        // R2: no strobe, value held although array input changes
        @(negedge clk);
        arr_rdata = 16'h0F0F;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold", rd_data, 16'hC3C3);
    endtask

    task automatic t_autosel;
        rd_chk("R5 id0", 8'h90, 8'h00, 16'hAAAA, 16'h0001);
        rd_chk("R5 id1", 8'h90, 8'h02, 16'hAAAA, 16'h227E);
        rd_chk("R5 protect", 8'h90, 8'h04, 16'hAAAA, 16'h0000);
        rd_chk("R6 id2", 8'h90, 8'h1C, 16'hAAAA, 16'h2213);
        rd_chk("R6 id3 absent", 8'h90, 8'h1E, 16'h7171, 16'h7171);
        rd_chk("R6 other offset", 8'h90, 8'h08, 16'h6262, 16'h6262);
        rd_chk("R3 low bit ignored", 8'h90, 8'h03, 16'hAAAA, 16'h227E);
    endtask

    task automatic t_status;
        load_status(8'h80);
        rd_chk("R7 first", 8'hA0, 8'h00, 16'h1111, 16'h0080);
        rd_chk("R7 toggled", 8'h10, 8'h00, 16'h1111, 16'h00C0);
        rd_chk("R7 toggled back", 8'h30, 8'h00, 16'h1111, 16'h0080);
        // R8: load and status read in one cycle; read sees old, load wins
        @(negedge clk);
        cmd_state = 8'hA0; rd_en = 1'b1; stat_ld = 1'b1; stat_val = 8'h11;
        @(negedge clk);
        rd_en = 1'b0; stat_ld = 1'b0;
        check("R8 read before load", rd_data, 16'h00C0);
        // R8: array reads leave status alone
        rd_chk("R8 array read", 8'h00, 8'h00, 16'h2222, 16'h2222);
        rd_chk("R8 load wins", 8'hA0, 8'h00, 16'h2222, 16'h0011);
    endtask

    task automatic t_query;
        rd_chk("R9 Q", 8'h98, 8'h20, 16'hFFFF, 16'h0051);
        rd_chk("R9 R", 8'h98, 8'h22, 16'hFFFF, 16'h0052);
        rd_chk("R9 Y", 8'h98, 8'h24, 16'hFFFF, 16'h0059);
        rd_chk("R9 cmd set", 8'h98, 8'h26, 16'hFFFF, 16'h0002);
        rd_chk("R3 odd address", 8'h98, 8'h21, 16'hFFFF, 16'h0051);
        rd_chk("R9 last entry area", 8'h98, 8'hA2, 16'hFFFF, 16'h0000);
        rd_chk("R9 beyond table", 8'h98, 8'hB0, 16'hFFFF, 16'h0000);
        rd_chk("R10 size", 8'h98, 8'h4E, 16'hFFFF, 16'h0017);
        rd_chk("R10 blocks lo", 8'h98, 8'h5A, 16'hFFFF, 16'h007F);
        rd_chk("R10 blocks hi", 8'h98, 8'h5C, 16'hFFFF, 16'h0000);
        rd_chk("R10 sector lo", 8'h98, 8'h5E, 16'hFFFF, 16'h0000);
        rd_chk("R10 sector hi", 8'h98, 8'h60, 16'hFFFF, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_array();
        t_autosel();
        t_status();
        t_query();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule